// File: doc/BRIEF.md
# Bit-Rate Tracking Clock Recovery

This block recovers bit timing from a serial receive line of the CAN kind for a low-power wake-up receiver. It keeps a running estimate of the bit length in oscillator ticks. The estimate starts from a configured nominal value. Each falling edge of the line realigns the bit phase. The phase error that the edge reveals then nudges the estimate by a selectable fraction of that error. After each adjustment the estimate must stay strictly inside a configured window. If it leaves the window, all acquired timing is thrown away and the nominal value is loaded again.

Inside every bit the line is sampled at a programmable fraction of the estimated bit length. The sampled level leaves the block together with a one-cycle strobe. A tick prescaler lets the same tick-based settings serve four oscillator rates. Configuration is meant to change only while the enable input is low. Raising enable restarts tracking from the current settings.

Top module: `brt_clock_recovery`

## Requirements
- R1: In reset `valid_o` is 0 and `bit_o` is 1. While `enable_i` is low, no strobe is produced, whatever the line does.
- R2: The line passes through a two-flop synchronizer. If `rxd_i` falls just before clock edge E0, the strobe for that bit is high in the cycle that follows edge E0+3+S, where S is the sample point.
- R3: The sample point S equals floor(estimate × `frac_i` / 64), with `frac_i` a 6-bit fraction. The usual setting is 51, about 80 %.
- R4: While the line has no falling edges, a strobe occurs once every estimate × 2^`clk_sel_i` clock cycles.
- R5: `clk_sel_i` = n makes the bit logic advance one tick every 2^n clock cycles, for n = 0..3. The estimate and the sample point are counted in ticks.
- R6: Let p be the tick phase reached at a falling edge, counted since the previous alignment modulo the estimate. The error is p when p < estimate/2 and p − estimate otherwise. The estimate becomes estimate + (error >>> (`filt_i` + 1)), so `filt_i` 0..3 gives weights of 1/2, 1/4, 1/8 and 1/16. The first falling edge after enable, or after a reload, only aligns the phase.
- R7: If an update would give a value ≥ `len_max_i` or ≤ `len_min_i`, the estimate reloads `nominal_i` and the next falling edge only aligns the phase.
- R8: `bit_o` carries the synchronized line level at the sample point, and `valid_o` is high for exactly one cycle per sampled bit.
- R9: When `enable_i` drops, `valid_o` is 0 from the next clock edge on and the bit phase returns to zero.
- R10: On every enable the estimate starts again from `nominal_i`, whatever was learned before. `nominal_i` must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the recovery when high |
| clk_sel_i | input | SEL_W | Tick prescale exponent (tick every 2^n cycles) |
| nominal_i | input | CNT_W | Nominal bit length in ticks |
| len_min_i | input | CNT_W | Lower bound of the estimate (exclusive) |
| len_max_i | input | CNT_W | Upper bound of the estimate (exclusive) |
| frac_i | input | FRAC_W | Sample point as a fraction of 64 |
| filt_i | input | 2 | Adjustment weight select |
| rxd_i | input | 1 | Asynchronous serial receive line |
| bit_o | output | 1 | Sampled data bit |
| valid_o | output | 1 | One-cycle strobe for `bit_o` |

## Verification
Some rules are checked by assertions on every cycle:
- the estimate either equals the nominal value or lies strictly inside its window;
- the phase stays below the estimate;
- a falling edge resets the phase;
- an aligning edge leaves the estimate unchanged;
- ticks never fall on two cycles in a row under a nonzero prescale;
- a low enable clears the strobe.

Other behaviour shows only in the bench scenarios:
- the final estimate each filter weight reaches, read from strobe spacing on an idle line;
- the reload that follows a bound hit;
- the exact cycle of the first sample for several fractions;
- the order of the recovered data bits.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;

   // Adjustment weight: select 0..3 maps to a right shift of 1..4
   typedef enum logic [1:0] {
      BRT_W_HALF      = 2'd0,
      BRT_W_QUARTER   = 2'd1,
      BRT_W_EIGHTH    = 2'd2,
      BRT_W_SIXTEENTH = 2'd3
   } brt_weight_e;

   function automatic logic [2:0] brt_shift(input logic [1:0] sel);
      return {1'b0, sel} + 3'd1;
   endfunction

endpackage

// File: rtl/brt_line_sync.sv
`timescale 1ns/1ps
module brt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rxd_i,
   output logic line_o,
   output logic fall_o
);
   logic [STAGES-1:0] sr_q;
   logic              hist_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("brt_line_sync: STAGES must be at least 2");
   end

   // Recessive (1) is the idle level, so reset to it
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q   <= '1;
         hist_q <= 1'b1;
      end else begin
         sr_q   <= {sr_q[STAGES-2:0], rxd_i};
         hist_q <= sr_q[STAGES-1];
      end
   end

   assign line_o = sr_q[STAGES-1];
   assign fall_o = hist_q & ~sr_q[STAGES-1];

endmodule

// File: rtl/brt_prescaler.sv
`timescale 1ns/1ps
module brt_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             resync_i,
   input  logic [SEL_W-1:0] clk_sel_i,
   output logic             tick_o
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("brt_prescaler: SEL_W must lie in 1..3");
   end

   assign lim    = DIV_W'((1 << clk_sel_i) - 1);
   assign tick_o = (cnt_q == lim);

   // Realigned by every falling edge, so ticks count from the edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (!en_i || resync_i) cnt_q <= '0;
      else if (tick_o)            cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end

   p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && tick_o && clk_sel_i != '0)
      |=> (!tick_o || clk_sel_i != $past(clk_sel_i)));

endmodule

// File: rtl/brt_estimator.sv
`timescale 1ns/1ps
module brt_estimator #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             fall_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] phase_i,
   input  logic [CNT_W-1:0] nominal_i,
   input  logic [CNT_W-1:0] len_min_i,
   input  logic [CNT_W-1:0] len_max_i,
   input  logic [1:0]       filt_i,
   output logic [CNT_W-1:0] est_o
);
   import brt_pkg::*;

   localparam int EW = CNT_W + 2;

   logic [CNT_W-1:0]    est_q;
   logic                locked_q;
   logic [CNT_W-1:0]    p_eff;
   logic [2:0]          shamt;
   logic signed [EW-1:0] err, step, est_nx;
   logic                out_of_window;

   always_comb begin
      // Phase this edge would reach after the tick of the current cycle
      if (tick_i) p_eff = (phase_i == est_q - 1'b1) ? '0 : phase_i + 1'b1;
      else        p_eff = phase_i;
      if (p_eff >= (est_q >> 1))
         err = $signed({2'b00, p_eff}) - $signed({2'b00, est_q});
      else
         err = $signed({2'b00, p_eff});
      shamt         = brt_shift(filt_i);
      step          = err >>> shamt;
      est_nx        = $signed({2'b00, est_q}) + step;
      out_of_window = (est_nx >= $signed({2'b00, len_max_i}))
                   || (est_nx <= $signed({2'b00, len_min_i}));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         est_q    <= '0;
         locked_q <= 1'b0;
      end else if (!run_i) begin
         est_q    <= nominal_i;
         locked_q <= 1'b0;
      end else if (fall_i) begin
         if (!locked_q) begin
            locked_q <= 1'b1;
         end else if (out_of_window) begin
            est_q    <= nominal_i;
            locked_q <= 1'b0;
         end else begin
            est_q    <= est_nx[CNT_W-1:0];
         end
      end
   end

   assign est_o = est_q;

   p_est_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> ((est_q == nominal_i) || (est_q > len_min_i && est_q < len_max_i)));

   p_align_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && fall_i && !locked_q) |=> (est_q == $past(est_q)));

endmodule

// File: rtl/brt_sampler.sv
`timescale 1ns/1ps
module brt_sampler #(
   parameter int CNT_W  = 12,
   parameter int FRAC_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              fall_i,
   input  logic              line_i,
   input  logic [CNT_W-1:0]  est_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic [CNT_W-1:0]  phase_o,
   output logic              bit_o,
   output logic              valid_o
);
   localparam int PW = CNT_W + FRAC_W;

   logic [CNT_W-1:0] phase_q;
   logic [PW-1:0]    prod;
   logic [CNT_W-1:0] spt;
   logic             valid_q, bit_q;

   assign prod = PW'(est_i) * PW'(frac_i);
   assign spt  = CNT_W'(prod >> FRAC_W);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
         valid_q <= 1'b0;
         bit_q   <= 1'b1;
      end else if (!run_i) begin
         phase_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (fall_i) begin
            phase_q <= '0;
         end else if (tick_i) begin
            if (phase_q == spt) begin
               valid_q <= 1'b1;
               bit_q   <= line_i;
            end
            phase_q <= (phase_q == est_i - 1'b1) ? '0 : phase_q + 1'b1;
         end
      end
   end

   assign phase_o = phase_q;
   assign bit_o   = bit_q;
   assign valid_o = valid_q;

   p_disable_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!valid_q && phase_q == '0));

   p_resync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && fall_i) |=> (phase_q == '0));

   p_phase_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && est_i != '0) |-> (phase_q < est_i));

endmodule

// File: rtl/brt_clock_recovery.sv
`timescale 1ns/1ps
module brt_clock_recovery #(
   parameter int CNT_W       = 12,
   parameter int FRAC_W      = 6,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [SEL_W-1:0]  clk_sel_i,
   input  logic [CNT_W-1:0]  nominal_i,
   input  logic [CNT_W-1:0]  len_min_i,
   input  logic [CNT_W-1:0]  len_max_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [1:0]        filt_i,
   input  logic              rxd_i,
   output logic              bit_o,
   output logic              valid_o
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("brt_clock_recovery: CNT_W must be at least 4");
   end
   if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_frac
      $error("brt_clock_recovery: FRAC_W must lie in 1..8");
   end

   logic             run_q, run;
   logic             line, fall, tick;
   logic [CNT_W-1:0] est, phase;

   // One cycle of load time: the estimate takes the nominal value first
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= 1'b0;
      else         run_q <= enable_i;
   end
   assign run = enable_i & run_q;

   brt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rxd_i  (rxd_i),
      .line_o (line),
      .fall_o (fall)
   );

   brt_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (run),
      .resync_i  (fall),
      .clk_sel_i (clk_sel_i),
      .tick_o    (tick)
   );

   brt_estimator #(.CNT_W(CNT_W)) u_est (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .fall_i    (fall),
      .tick_i    (tick),
      .phase_i   (phase),
      .nominal_i (nominal_i),
      .len_min_i (len_min_i),
      .len_max_i (len_max_i),
      .filt_i    (filt_i),
      .est_o     (est)
   );

   brt_sampler #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_smp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .tick_i  (tick),
      .fall_i  (fall),
      .line_i  (line),
      .est_i   (est),
      .frac_i  (frac_i),
      .phase_o (phase),
      .bit_o   (bit_o),
      .valid_o (valid_o)
   );

   p_enable_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> !valid_o);

endmodule

// File: tb/brt_clock_recovery_bench.sv
`timescale 1ns/1ps
module brt_clock_recovery_bench;

   typedef struct packed {
      logic [1:0]  sel;
      logic [11:0] nom;
      logic [11:0] lo;
      logic [11:0] hi;
      logic [1:0]  filt;
      logic [15:0] blen;
      logic [15:0] expi;
   } vec_t;

   // sel, nominal, min, max, weight, bit length (cycles), expected idle strobe spacing
   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 16'd20, 16'd20},
      '{2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 16'd24, 16'd24},
      '{2'd0, 12'd20, 12'd10, 12'd40, 2'd1, 16'd24, 16'd23},
      '{2'd0, 12'd20, 12'd10, 12'd40, 2'd2, 16'd24, 16'd21},
      '{2'd0, 12'd20, 12'd10, 12'd40, 2'd3, 16'd24, 16'd20},
      '{2'd0, 12'd20, 12'd10, 12'd22, 2'd0, 16'd24, 16'd20},
      '{2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 16'd16, 16'd16},
      '{2'd0, 12'd20, 12'd17, 12'd40, 2'd0, 16'd16, 16'd20},
      '{2'd1, 12'd10, 12'd5,  12'd20, 2'd0, 16'd20, 16'd20}
   };

   localparam int WD_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  clk_sel = '0;
   logic [11:0] nominal = 12'd20;
   logic [11:0] len_min = 12'd10;
   logic [11:0] len_max = 12'd40;
   logic [5:0]  frac = 6'd51;
   logic [1:0]  filt = '0;
   logic        rxd = 1'b1;
   logic        bit_o, valid_o;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   brt_clock_recovery u_brt_clock_recovery (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .enable_i  (enable),
      .clk_sel_i (clk_sel),
      .nominal_i (nominal),
      .len_min_i (len_min),
      .len_max_i (len_max),
      .frac_i    (frac),
      .filt_i    (filt),
      .rxd_i     (rxd),
      .bit_o     (bit_o),
      .valid_o   (valid_o)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic setup(input logic [1:0] s, input logic [11:0] nm, input logic [11:0] lo,
                        input logic [11:0] hi, input logic [1:0] f, input logic [5:0] fr);
      @(negedge clk);
      enable = 1'b0;
      rxd = 1'b1;
      clk_sel = s; nominal = nm; len_min = lo; len_max = hi; filt = f; frac = fr;
      repeat (4) @(negedge clk);
      enable = 1'b1;
      repeat (60) @(negedge clk);
   endtask

   task automatic idle_spacing(output int gap);
      int t0;
      while (!valid_o) @(negedge clk);
      t0 = cyc;
      @(negedge clk);
      while (!valid_o) @(negedge clk);
      gap = cyc - t0;
   endtask

   task automatic first_delay(output int d, output int b);
      int n;
      n = cyc;
      rxd = 1'b0;
      d = -1;
      b = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (i == 19) rxd = 1'b1;
         if (valid_o && cyc > n + 3 && d < 0) begin
            d = cyc - n;
            b = int'(bit_o);
         end
      end
   endtask

   localparam logic [7:0] PAT = 8'b0100_0110; // sent LSB first: 0,1,1,0,0,0,1,0

   initial begin
      int gap, d, b, n, got, nval;
      int bits [8];

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(valid_o), 0);
      chk("R1 bit in reset", int'(bit_o), 1);
      rst_n = 1'b1;

      // R1: no strobe while disabled even with line activity
      nval = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         rxd = ((i / 15) % 2) == 0;
         if (valid_o) nval++;
      end
      rxd = 1'b1;
      chk("R1 strobes while disabled", nval, 0);

      // Vector table: R4 R5 R6 R7 via idle strobe spacing after a training frame
      for (int v = 0; v < NV; v++) begin
         setup(VEC[v].sel, VEC[v].nom, VEC[v].lo, VEC[v].hi, VEC[v].filt, 6'd51);
         for (int e = 0; e < 6; e++) begin
            rxd = 1'b0;
            repeat (int'(VEC[v].blen)) @(negedge clk);
            rxd = 1'b1;
            repeat (int'(VEC[v].blen)) @(negedge clk);
         end
         repeat (2 * int'(VEC[v].expi)) @(negedge clk);
         idle_spacing(gap);
         chk($sformatf("R4 R5 R6 R7 vector %0d spacing", v), gap, int'(VEC[v].expi));
      end

      // R2 R3 R8: first sample position and value for several fractions
      setup(2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 6'd51);
      first_delay(d, b);
      chk("R2 R3 delay frac 51", d, 19);
      chk("R8 sampled dominant", b, 0);
      setup(2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 6'd32);
      first_delay(d, b);
      chk("R3 delay frac 32", d, 14);
      setup(2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 6'd0);
      first_delay(d, b);
      chk("R3 delay frac 0", d, 4);

      // R8: data bit order at nominal rate
      setup(2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 6'd51);
      n = cyc;
      got = 0;
      fork
         begin
            for (int i = 0; i < 8; i++) begin
               rxd = PAT[i];
               repeat (20) @(negedge clk);
            end
            rxd = 1'b1;
         end
         begin
            while (got < 8) begin
               @(negedge clk);
               if (valid_o && cyc > n + 3) begin
                  bits[got] = int'(bit_o);
                  got++;
               end
            end
         end
      join
      for (int i = 0; i < 8; i++)
         chk($sformatf("R8 data bit %0d", i), bits[i], int'(PAT[i]));

      // R4: idle spacing equals nominal after the frame
      repeat (30) @(negedge clk);
      idle_spacing(gap);
      chk("R4 idle spacing", gap, 20);

      // R9: enable drop clears the strobe at once and for good
      while (!valid_o) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk("R9 strobe after disable", int'(valid_o), 0);
      nval = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (valid_o) nval++;
      end
      chk("R9 strobes while off", nval, 0);

      // R10: a learned estimate of 24 is forgotten on the next enable
      setup(2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 6'd51);
      for (int e = 0; e < 4; e++) begin
         rxd = 1'b0; repeat (24) @(negedge clk);
         rxd = 1'b1; repeat (24) @(negedge clk);
      end
      setup(2'd0, 12'd20, 12'd10, 12'd40, 2'd0, 6'd51);
      idle_spacing(gap);
      chk("R10 restart from nominal", gap, 20);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule